// File: doc/BRIEF.md
# Injected Conversion Trigger Sequencer

This block decides when a group of injected analog-to-digital conversions begins and then walks the converter through each conversion of that group. Software programs three fields through a write port: a two-bit trigger mode (off, rising edge, falling edge or both edges), a selector that picks one of the external event lines as the hardware trigger source, and a two-bit length that sets how many conversions the group contains. The selected event line passes through a two-stage synchronizer and an edge detector, so a qualified edge becomes a single-cycle trigger.

A software start strobe is honoured whenever the trigger mode is not off. When the mode is off, the queue-disable input decides whether software may still start a group. When queue mode is set and the context queue reports empty, hardware and software triggers are both suppressed. Once a group is running, the block issues one conversion start pulse per index, waits for the converter's completion handshake, and after the last completion it raises a one-cycle done pulse and returns to idle. Triggers and configuration writes that arrive while a group is running are discarded.

Top module: `injseq_top`

## Requirements
- R1: With trigger mode 01, a rising edge on the selected event line starts a group: the conversion start output goes high in the third clock after the line changes (two synchronizer stages plus the sequencer register), and a falling edge starts nothing.
- R2: With trigger mode 10, a falling edge on the selected event line starts a group with the same latency, and a rising edge starts nothing.
- R3: With trigger mode 11, both rising and falling edges on the selected event line start a group.
- R4: With trigger mode 00 and queue-disable low, neither the software start strobe nor event edges start a group.
- R5: With trigger mode 00 and queue-disable high, event edges are ignored but a software start strobe starts a group; a software strobe starts a group in any non-zero mode, with conversion start high in the clock after the strobe.
- R6: The event selector value n (0 to NUM_EVENTS-1) makes event line n the only hardware trigger source; edges on other lines start nothing.
- R7: A length field value L gives exactly L+1 conversions, the sequence index reading 0, 1, ... L with each start pulse.
- R8: Configuration writes made while a group is running (from the first start pulse until the done pulse is gone) are discarded; the earlier mode, selector and length remain in force.
- R9: When queue mode and queue-empty are both high, software and hardware triggers are suppressed; with either one low, triggers work normally.
- R10: Triggers arriving while a group runs are ignored and not stored: no new group starts after the running one finishes.
- R11: Each conversion start is a one-cycle pulse; after a completion handshake that is not the last, the next start pulse appears in the following cycle; after the last completion the done output is high for exactly one cycle with no start pulse, and the block goes idle.
- R12: After reset the outputs are low, the index is 0 and all fields are zero (mode off, selector 0, length one conversion).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Write strobe for the three configuration fields |
| cfgTrigMode | input | 2 | Trigger mode: 00 off, 01 rising, 10 falling, 11 both |
| cfgEventSel | input | 5 | Index of the external event line used as hardware trigger |
| cfgSeqLen | input | 2 | Conversions in the group minus one |
| events | input | 32 | External event lines, asynchronous |
| swStart | input | 1 | Software start strobe |
| queueDisable | input | 1 | High lets software start a group while mode is off |
| queueMode | input | 1 | Queue mode enable |
| queueEmpty | input | 1 | Context queue empty flag |
| convDone | input | 1 | Conversion-complete handshake from the converter |
| convStart | output | 1 | One-cycle pulse that starts one conversion |
| seqIndex | output | 2 | Index of the conversion being started |
| seqDone | output | 1 | One-cycle pulse after the group's last completion |

## Verification
The bench builds the block with its default parameters: 32 event lines, a two-stage synchronizer and a two-bit length field. That makes the top event line 31 selectable as a boundary case of the selector, lets the full four-conversion group be counted index by index, and fixes the hardware trigger latency at three clocks so each edge test can sample the start pulse in one exact cycle.

// File: rtl/injseq_pkg.sv
package injseq_pkg;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'b00,
    TRIG_RISE = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_BOTH = 2'b11
  } trigMode_t;

  typedef struct packed {
    logic clearIdx;
    logic incIdx;
    logic busy;
  } ctrlStrobes_t;

endpackage

// File: rtl/injseq_datapath.sv
module injseq_datapath
  import injseq_pkg::*;
#(
  parameter int NUM_EVENTS  = 32,
  parameter int SYNC_STAGES = 2,
  parameter int LEN_W       = 2,
  localparam int SEL_W      = $clog2(NUM_EVENTS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [1:0]         cfgTrigMode,
  input  logic [SEL_W-1:0]   cfgEventSel,
  input  logic [LEN_W-1:0]   cfgSeqLen,
  input  logic [NUM_EVENTS-1:0] events,
  input  logic               swStart,
  input  logic               queueDisable,
  input  logic               queueMode,
  input  logic               queueEmpty,
  input  ctrlStrobes_t       strobes,
  output logic               trigger,
  output logic               isLast,
  output logic [LEN_W-1:0]   seqIndex
);

  trigMode_t         trigMode;
  logic [SEL_W-1:0]  eventSel;
  logic [LEN_W-1:0]  seqLen;
  logic              selLine;
  logic [SYNC_STAGES-1:0] syncChain;
  logic              syncPrev;
  logic              riseSeen;
  logic              fallSeen;
  logic              hwEdge;
  logic              queueBlock;
  logic              swAllowed;

  // configuration fields, frozen while a group runs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigMode <= TRIG_OFF;
      eventSel <= '0;
      seqLen   <= '0;
    end else if (cfgWrEn && !strobes.busy) begin
      trigMode <= trigMode_t'(cfgTrigMode);
      eventSel <= cfgEventSel;
      seqLen   <= cfgSeqLen;
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    strobes.busy |=> ($stable(seqLen) && $stable(trigMode) && $stable(eventSel))); // R8

  assign selLine = events[eventSel];

  // synchronizer chain for the selected line
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= selLine;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], selLine};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPrev <= 1'b0;
    else       syncPrev <= syncChain[SYNC_STAGES-1];
  end

  assign riseSeen = syncChain[SYNC_STAGES-1] && !syncPrev;
  assign fallSeen = !syncChain[SYNC_STAGES-1] && syncPrev;

  always_comb begin
    unique case (trigMode)
      TRIG_RISE: hwEdge = riseSeen;
      TRIG_FALL: hwEdge = fallSeen;
      TRIG_BOTH: hwEdge = riseSeen || fallSeen;
      default:   hwEdge = 1'b0;
    endcase
  end

  assign queueBlock = queueMode && queueEmpty;
  assign swAllowed  = (trigMode != TRIG_OFF) || queueDisable;
  assign trigger    = !queueBlock && (hwEdge || (swStart && swAllowed));

  // sequence index counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 seqIndex <= '0;
    else if (strobes.clearIdx) seqIndex <= '0;
    else if (strobes.incIdx)   seqIndex <= seqIndex + 1'b1;
  end

  assign isLast = (seqIndex == seqLen);

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    strobes.busy |-> (seqIndex <= seqLen)); // R7

  AST_NO_OFF_HW: assert property (@(posedge clk) disable iff (!rstN)
    (trigMode == TRIG_OFF && !queueDisable) |-> !trigger); // R4

endmodule

// File: rtl/injseq_control.sv
module injseq_control
  import injseq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         trigger,
  input  logic         isLast,
  input  logic         convDone,
  output ctrlStrobes_t strobes,
  output logic         convStart,
  output logic         seqDone
);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_START = 2'b01,
    ST_WAIT  = 2'b10,
    ST_DONE  = 2'b11
  } seqState_t;

  seqState_t state;
  seqState_t nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:  if (trigger) nextState = ST_START;
      ST_START: nextState = ST_WAIT;
      ST_WAIT:  if (convDone) nextState = isLast ? ST_DONE : ST_START;
      ST_DONE:  nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign strobes.clearIdx = (state == ST_IDLE) && trigger;
  assign strobes.incIdx   = (state == ST_WAIT) && convDone && !isLast;
  assign strobes.busy     = (state != ST_IDLE);

  assign convStart = (state == ST_START);
  assign seqDone   = (state == ST_DONE);

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart); // R11

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> (!seqDone && !convStart)); // R11

  AST_NEXT_START: assert property (@(posedge clk) disable iff (!rstN)
    strobes.incIdx |=> convStart); // R11

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.busy && !convStart && !convDone && !seqDone) |=> !convStart); // R10

endmodule

// File: rtl/injseq_top.sv
module injseq_top
  import injseq_pkg::*;
#(
  parameter int NUM_EVENTS  = 32,
  parameter int SYNC_STAGES = 2,
  parameter int LEN_W       = 2,
  localparam int SEL_W      = $clog2(NUM_EVENTS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWrEn,
  input  logic [1:0]            cfgTrigMode,
  input  logic [SEL_W-1:0]      cfgEventSel,
  input  logic [LEN_W-1:0]      cfgSeqLen,
  input  logic [NUM_EVENTS-1:0] events,
  input  logic                  swStart,
  input  logic                  queueDisable,
  input  logic                  queueMode,
  input  logic                  queueEmpty,
  input  logic                  convDone,
  output logic                  convStart,
  output logic [LEN_W-1:0]      seqIndex,
  output logic                  seqDone
);

  ctrlStrobes_t strobes;
  logic         trigger;
  logic         isLast;

  injseq_datapath #(
    .NUM_EVENTS (NUM_EVENTS),
    .SYNC_STAGES(SYNC_STAGES),
    .LEN_W      (LEN_W)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .cfgWrEn     (cfgWrEn),
    .cfgTrigMode (cfgTrigMode),
    .cfgEventSel (cfgEventSel),
    .cfgSeqLen   (cfgSeqLen),
    .events      (events),
    .swStart     (swStart),
    .queueDisable(queueDisable),
    .queueMode   (queueMode),
    .queueEmpty  (queueEmpty),
    .strobes     (strobes),
    .trigger     (trigger),
    .isLast      (isLast),
    .seqIndex    (seqIndex)
  );

  injseq_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .trigger  (trigger),
    .isLast   (isLast),
    .convDone (convDone),
    .strobes  (strobes),
    .convStart(convStart),
    .seqDone  (seqDone)
  );

  AST_QUEUE_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.busy && queueMode && queueEmpty) |=> !convStart); // R9

  AST_FIRST_IDX: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.busy && trigger) |=> (convStart && seqIndex == '0)); // R7

endmodule

// File: tb/injseq_top_test.sv
module injseq_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int NEV = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [1:0] cfgTrigMode = 2'b00;
  logic [4:0] cfgEventSel = 5'd0;
  logic [1:0] cfgSeqLen = 2'b00;
  logic [NEV-1:0] events = '0;
  logic swStart = 1'b0;
  logic queueDisable = 1'b0;
  logic queueMode = 1'b0;
  logic queueEmpty = 1'b0;
  logic convDone = 1'b0;
  logic convStart;
  logic [1:0] seqIndex;
  logic seqDone;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  injseq_top uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgTrigMode(cfgTrigMode),
    .cfgEventSel(cfgEventSel), .cfgSeqLen(cfgSeqLen), .events(events),
    .swStart(swStart), .queueDisable(queueDisable), .queueMode(queueMode),
    .queueEmpty(queueEmpty), .convDone(convDone), .convStart(convStart),
    .seqIndex(seqIndex), .seqDone(seqDone)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [1:0] m, input logic [4:0] s, input logic [1:0] l);
    cfgTrigMode = m; cfgEventSel = s; cfgSeqLen = l; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // software strobe for one cycle; returns at the negedge where convStart should show
  task automatic pulseSw();
    swStart = 1'b1;
    @(negedge clk);
    swStart = 1'b0;
  endtask

  // drive event line, wait three clocks
  task automatic driveEvent(input int line, input logic val);
    events[line] = val;
    repeat (3) @(negedge clk);
  endtask

  task automatic expectNoStart(input int cycles, input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      if (convStart) seen = 1'b1;
      @(negedge clk);
    end
    if (convStart) seen = 1'b1;
    check(!seen, tag, int'(seen), 0);
  endtask

  // caller is at the negedge where the first start pulse should be visible
  task automatic runConv(input int n, input string tag);
    check(convStart && seqIndex == 2'd0, {tag, " first start"}, int'(convStart), 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(!convStart, {tag, " R11 start is one cycle"}, int'(convStart), 0);
      convDone = 1'b1;
      @(negedge clk);
      convDone = 1'b0;
      if (i < n - 1) begin
        check(convStart && !seqDone, {tag, " R11 next start"}, int'(convStart), 1);
        check(int'(seqIndex) == i + 1, {tag, " R7 index"}, int'(seqIndex), i + 1);
      end else begin
        check(seqDone && !convStart, {tag, " R11 done pulse"}, int'(seqDone), 1);
      end
    end
    @(negedge clk);
    check(!seqDone && !convStart, {tag, " R11 done one cycle"}, int'(seqDone), 0);
  endtask

  task automatic testReset();
    check(!convStart && !seqDone && seqIndex == 2'd0, "R12 outputs after reset",
          int'(convStart) + int'(seqDone) + int'(seqIndex), 0);
    queueDisable = 1'b0;
    pulseSw();
    expectNoStart(4, "R12 mode field zero after reset");
    queueDisable = 1'b1;
    pulseSw();
    runConv(1, "R12 length zero after reset");
    queueDisable = 1'b0;
  endtask

  task automatic testModeOff();
    writeCfg(2'b00, 5'd3, 2'b00);
    queueDisable = 1'b0;
    pulseSw();
    expectNoStart(3, "R4 sw ignored when off");
    driveEvent(3, 1'b1);
    expectNoStart(3, "R4 hw rise ignored when off");
    queueDisable = 1'b1;
    driveEvent(3, 1'b0);
    expectNoStart(3, "R5 hw fall ignored when off");
    pulseSw();
    runConv(1, "R5 sw start with queue disabled");
    queueDisable = 1'b0;
  endtask

  task automatic testRising();
    writeCfg(2'b01, 5'd7, 2'b00);
    events[7] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!convStart, "R1 no start before sync latency", int'(convStart), 0);
    @(negedge clk);
    runConv(1, "R1 rising start");
    driveEvent(7, 1'b0);
    expectNoStart(3, "R1 falling ignored");
  endtask

  task automatic testFalling();
    writeCfg(2'b10, 5'd9, 2'b00);
    driveEvent(9, 1'b1);
    expectNoStart(3, "R2 rising ignored");
    driveEvent(9, 1'b0);
    runConv(1, "R2 falling start");
  endtask

  task automatic testBoth();
    writeCfg(2'b11, 5'd2, 2'b01);
    driveEvent(2, 1'b1);
    runConv(2, "R3 rise start");
    driveEvent(2, 1'b0);
    runConv(2, "R3 fall start");
  endtask

  task automatic testSelect();
    writeCfg(2'b01, 5'd31, 2'b00);
    driveEvent(30, 1'b1);
    expectNoStart(3, "R6 other line ignored");
    driveEvent(31, 1'b1);
    runConv(1, "R6 line 31 selected");
    events[30] = 1'b0; events[31] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic testLength();
    writeCfg(2'b01, 5'd0, 2'b11);
    pulseSw();
    runConv(4, "R7 four conversions");
    writeCfg(2'b01, 5'd0, 2'b10);
    pulseSw();
    runConv(3, "R7 three conversions");
  endtask

  task automatic testBlockedWrite();
    writeCfg(2'b01, 5'd0, 2'b00);
    queueDisable = 1'b0;
    pulseSw();
    check(convStart, "R8 started", int'(convStart), 1);
    cfgTrigMode = 2'b00; cfgSeqLen = 2'b11; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
    convDone = 1'b1;
    @(negedge clk);
    convDone = 1'b0;
    check(seqDone && !convStart, "R8 length write discarded", int'(seqDone), 1);
    @(negedge clk);
    pulseSw();
    runConv(1, "R8 mode and length kept");
  endtask

  task automatic testBusyIgnore();
    writeCfg(2'b01, 5'd4, 2'b01);
    pulseSw();
    @(negedge clk);
    swStart = 1'b1;
    events[4] = 1'b1;
    @(negedge clk);
    swStart = 1'b0;
    repeat (3) @(negedge clk);
    check(!convStart, "R10 no extra start while busy", int'(convStart), 0);
    convDone = 1'b1;
    @(negedge clk);
    convDone = 1'b0;
    check(convStart && seqIndex == 2'd1, "R10 sequence continues", int'(seqIndex), 1);
    @(negedge clk);
    convDone = 1'b1;
    @(negedge clk);
    convDone = 1'b0;
    check(seqDone, "R10 done", int'(seqDone), 1);
    expectNoStart(6, "R10 trigger not queued");
    events[4] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic testQueue();
    writeCfg(2'b01, 5'd6, 2'b00);
    queueMode = 1'b1; queueEmpty = 1'b1;
    pulseSw();
    expectNoStart(3, "R9 sw suppressed");
    driveEvent(6, 1'b1);
    expectNoStart(3, "R9 hw suppressed");
    events[6] = 1'b0;
    repeat (4) @(negedge clk);
    queueEmpty = 1'b0;
    pulseSw();
    runConv(1, "R9 queue not empty");
    queueMode = 1'b0; queueEmpty = 1'b1;
    pulseSw();
    runConv(1, "R9 queue mode off");
    queueEmpty = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testModeOff();
    testRising();
    testFalling();
    testBoth();
    testSelect();
    testLength();
    testBlockedWrite();
    testBusyIgnore();
    testQueue();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule